// File: doc/BRIEF.md
# Status-Polling Channel Service Multiplexer

This block schedules word-transfer slots for four serial channel controllers. A polling cycle begins on a cycle-start tick: the block captures a status word with one request bit per channel and marks the start of the cycle with a single-clock pulse. It then serves each channel whose bit was captured, from channel 3 down to channel 0. For each one it raises that channel's grant and holds it until the channel returns a done pulse. When every captured request has been served, it goes back to waiting for the next tick. A channel that never answers loses its grant after a programmable number of clocks, so one stuck controller cannot stall the others.

The length of each polling cycle is measured in microseconds with a clock prescaler, starting at the sampling edge. A cycle that runs longer than the deadline sets a sticky overrun flag. The flag stays set until reset and tells the system that the channels were not all served in time.

Top module: `chan_poll_mux`

## Requirements
- R1: After reset, all grants are 0, the cycle-start pulse is 0 and the overrun flag is 0.
- R2: Status is captured only on a clock edge where the block is idle and `poll_tick` is 1. `cycle_start_o` is 1 for exactly the one clock that follows that edge.
- R3: If the captured status is 0, no grant is raised, and later status changes cause no grant until the next `poll_tick`.
- R4: Channels are served in descending index order (bit 3 first, bit 0 last). Only the bits set at capture time are served, and status changes during the cycle are ignored.
- R5: At most one grant bit is 1 at any time. A grant stays on until its own channel's `done_i` bit is seen, and `done_i` bits of other channels have no effect.
- R6: The clock after the granted channel's done is seen, the grant moves to the next captured channel, or falls to 0 if none is left.
- R7: A grant that gets no done is dropped after exactly `GRANT_TIMEOUT` clocks, and service moves on to the next channel.
- R8: A `poll_tick` that arrives while channels are being served starts no new cycle and gives no `cycle_start_o` pulse.
- R9: The cycle length is counted in units of `CLK_PER_US` clocks from the capture edge. Once the count exceeds `DEADLINE_US`, `overrun_o` goes to 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| poll_tick | input | 1 | Request to start a polling cycle |
| status_i | input | NCH | One request bit per channel |
| done_i | input | NCH | Per-channel word-transfer done pulse |
| grant_o | output | NCH | One-hot grant to the channel being served |
| cycle_start_o | output | 1 | One-clock pulse marking a status capture |
| overrun_o | output | 1 | Sticky flag: a polling cycle exceeded the deadline |

## Verification
The pending-request register shows up directly on `grant_o`. A bit that is lost or left behind shows as a missing channel or an extra grant in the service order, one clock after the done that precedes it. A wrong timeout counter shows as a grant held a different number of clocks than `GRANT_TIMEOUT`, measured on the first grant that is not answered. A fault in the cycle-length counter takes longer to see: it appears only when a cycle crosses the deadline, as a missing or early `overrun_o`. So the bench builds cycles that fall clearly on each side of the limit.

// File: rtl/chpoll_pkg.sv
// Package: shared types for the channel polling multiplexer.
// Assumes: none; only type definitions live here.
package chpoll_pkg;

    // Scheduler phase: waiting for a tick, or serving captured requests.
    typedef enum logic {
        PH_WAIT  = 1'b0,
        PH_SERVE = 1'b1
    } poll_phase_t;

endpackage

// File: rtl/chpoll_pick.sv
// Module: fixed-priority picker, highest index wins.
// Assumes: req is a pending mask; output is one-hot or zero.
module chpoll_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] sel
);

    // Each bit is selected only when no higher-index bit is pending.
    for (genvar i = 0; i < N; i++) begin : g_pick
        if (i == N - 1) begin : g_top
            assign sel[i] = req[i];
        end else begin : g_low
            assign sel[i] = req[i] & ~(|req[N-1:i+1]);
        end
    end

    // Keeps the priority output one-hot for the grant path (R5).
    always_comb begin
        p_pick_onehot_r5: assert ($onehot0(sel) || $isunknown(req));
    end

endmodule

// File: rtl/chpoll_wait_timer.sv
// Module: counts the clocks a grant has been held and signals expiry.
// Assumes: 'run' is high while a grant is out; 'adv' is high on the clock
//          where service moves on, so the next grant starts from zero.
module chpoll_wait_timer #(
    parameter int TIMEOUT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic adv,
    output logic expire
);

    localparam int CW = $clog2(TIMEOUT + 1);

    logic [CW-1:0] cnt;

    // Counts held clocks, restarting at every grant hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || adv) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && (cnt == CW'(TIMEOUT - 1));

    // The count never passes the timeout limit (R7).
    p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(TIMEOUT));

endmodule

// File: rtl/chpoll_deadline.sv
// Module: measures polling-cycle length in microseconds and raises a
//         sticky flag when the length passes the deadline.
// Assumes: 'start' pulses on the capture edge of a cycle with requests;
//          'active' is high for every clock of the service phase.
module chpoll_deadline #(
    parameter int CLK_PER_US  = 125,
    parameter int DEADLINE_US = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    output logic overrun
);

    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam int UW = $clog2(DEADLINE_US + 2);
    localparam logic [UW-1:0] US_CAP = UW'(DEADLINE_US + 1);

    logic [PW-1:0] pre;
    logic [UW-1:0] us_cnt;

    // Divides the clock down to microsecond steps and counts them.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            pre    <= '0;
            us_cnt <= '0;
        end else if (active) begin
            if (pre == PW'(CLK_PER_US - 1)) begin
                pre <= '0;
                if (us_cnt != US_CAP) begin
                    us_cnt <= us_cnt + 1'b1;
                end
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

    // Latches the overrun condition until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (active && us_cnt > UW'(DEADLINE_US)) begin
            overrun <= 1'b1;
        end
    end

    // Once set, the flag is never cleared (R9).
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // The flag only rises during a service phase (R9).
    p_overrun_in_service_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(active));

endmodule

// File: rtl/chan_poll_mux.sv
// Module: polling scheduler for NCH channel controllers. On a tick, while
//         idle, it captures the status word. It then grants one word slot
//         to each captured channel from the highest index down, and
//         returns to idle.
// Assumes: done_i is a pulse from the granted channel; other bits of done_i
//          are ignored. poll_tick may arrive at any time.
module chan_poll_mux
    import chpoll_pkg::*;
#(
    parameter int NCH           = 4,
    parameter int CLK_PER_US    = 125,
    parameter int DEADLINE_US   = 250,
    parameter int GRANT_TIMEOUT = 4096
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           poll_tick,
    input  logic [NCH-1:0] status_i,
    input  logic [NCH-1:0] done_i,
    output logic [NCH-1:0] grant_o,
    output logic           cycle_start_o,
    output logic           overrun_o
);

    poll_phase_t    phase;
    logic [NCH-1:0] pend;
    logic [NCH-1:0] pick;
    logic [NCH-1:0] pend_left;
    logic           capture;
    logic           hit;
    logic           expire;
    logic           adv;

    chpoll_pick #(.N(NCH)) u_pick (
        .req (pend),
        .sel (pick)
    );

    // Grant comes straight from the priority pick during service.
    assign grant_o   = (phase == PH_SERVE) ? pick : '0;
    assign hit       = |(done_i & grant_o);
    assign adv       = (phase == PH_SERVE) && (hit || expire);
    assign pend_left = pend & ~grant_o;
    assign capture   = (phase == PH_WAIT) && poll_tick;

    chpoll_wait_timer #(.TIMEOUT(GRANT_TIMEOUT)) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (phase == PH_SERVE),
        .adv    (adv),
        .expire (expire)
    );

    chpoll_deadline #(
        .CLK_PER_US  (CLK_PER_US),
        .DEADLINE_US (DEADLINE_US)
    ) u_deadline (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (capture && (status_i != '0)),
        .active  (phase == PH_SERVE),
        .overrun (overrun_o)
    );

    // Phase sequencing and the pending-request mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_WAIT;
            pend  <= '0;
        end else if (capture) begin
            pend  <= status_i;
            phase <= (status_i != '0) ? PH_SERVE : PH_WAIT;
        end else if (adv) begin
            pend  <= pend_left;
            if (pend_left == '0) begin
                phase <= PH_WAIT;
            end
        end
    end

    // One-clock marker for each status capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cycle_start_o <= 1'b0;
        end else begin
            cycle_start_o <= capture;
        end
    end

    // Never more than one grant at a time (R5).
    p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // A grant with no done and no expiry is held into the next clock (R5).
    p_grant_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && !hit && !expire) |=> (grant_o == $past(grant_o)));

    // After a hand-over the grant goes only to a lower index, or to none (R4).
    p_desc_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && (hit || expire)) |=>
            (grant_o == '0 || grant_o < $past(grant_o)));

    // A capture happens only when no grant was out (R8).
    p_start_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_o |-> ($past(grant_o) == '0));

endmodule

// File: tb/chan_poll_mux_tb.sv
module chan_poll_mux_tb;

    localparam int NCH = 4;
    localparam int CPU = 2;
    localparam int DL  = 10;
    localparam int TMO = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           poll_tick = 1'b0;
    logic [NCH-1:0] status_i = '0;
    logic [NCH-1:0] done_i = '0;
    logic [NCH-1:0] grant_o;
    logic           cycle_start_o;
    logic           overrun_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [NCH-1:0] resp_mask = '0;
    logic [NCH-1:0] frc_done = '0;
    int log_ch [16];
    int log_len [16];
    int log_n = 0;

    always #4 clk = ~clk;

    chan_poll_mux #(
        .NCH(NCH), .CLK_PER_US(CPU), .DEADLINE_US(DL), .GRANT_TIMEOUT(TMO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .poll_tick(poll_tick), .status_i(status_i),
        .done_i(done_i), .grant_o(grant_o), .cycle_start_o(cycle_start_o),
        .overrun_o(overrun_o)
    );

    // Channel model: answers on the third clock of a grant, logs grant order.
    initial begin
        logic [NCH-1:0] prev_g;
        int gcnt;
        prev_g = '0;
        gcnt = 0;
        forever begin
            @(negedge clk);
            if (grant_o != prev_g) begin
                if (prev_g != '0 && log_n > 0) log_len[log_n-1] = gcnt + 1;
                if (grant_o != '0 && log_n < 16) begin
                    for (int i = 0; i < NCH; i++)
                        if (grant_o[i]) log_ch[log_n] = i;
                    log_n++;
                end
                gcnt = 0;
            end else begin
                gcnt++;
            end
            prev_g = grant_o;
            done_i = ((gcnt == 2) ? (grant_o & resp_mask) : '0) | frc_done;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        poll_tick = 1'b1;
        @(negedge clk);
        poll_tick = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(grant_o == '0, "R1 grant", grant_o, 0);
        chk(cycle_start_o == 1'b0, "R1 cycle_start", cycle_start_o, 0);
        chk(overrun_o == 1'b0, "R1 overrun", overrun_o, 0);
    endtask

    // R2/R3: empty status gives a pulse but no grant; later status needs a tick.
    task automatic t_empty();
        status_i = '0;
        tick();
        chk(cycle_start_o == 1'b1, "R2 pulse high", cycle_start_o, 1);
        @(negedge clk);
        chk(cycle_start_o == 1'b0, "R2 pulse one clock", cycle_start_o, 0);
        status_i = 4'b0010;
        settle(10);
        chk(grant_o == '0, "R3 no grant without tick", grant_o, 0);
        resp_mask = '1;
        tick();
        chk(grant_o == 4'b0010, "R3 grant after tick", grant_o, 2);
        status_i = '0;
        settle(10);
    endtask

    // R4/R6: descending order, only captured bits, hand-over on next clock.
    task automatic t_order();
        resp_mask = '1;
        log_n = 0;
        status_i = 4'b1011;
        tick();
        status_i = 4'b1111;
        settle(20);
        status_i = '0;
        chk(log_n == 3, "R4 served count", log_n, 3);
        chk(log_ch[0] == 3 && log_ch[1] == 1 && log_ch[2] == 0, "R4 order",
            log_ch[0] * 100 + log_ch[1] * 10 + log_ch[2], 310);
        chk(log_len[0] == 3 && log_len[1] == 3 && log_len[2] == 3, "R6 hold length",
            log_len[0] * 100 + log_len[1] * 10 + log_len[2], 333);
        chk(grant_o == '0, "R6 idle after last", grant_o, 0);
    endtask

    // R5: a done from another channel leaves the grant in place.
    task automatic t_other_done();
        resp_mask = '0;
        status_i = 4'b0100;
        tick();
        status_i = '0;
        frc_done = 4'b0001;
        settle(3);
        chk(grant_o == 4'b0100, "R5 foreign done ignored", grant_o, 4);
        frc_done = 4'b0100;
        @(negedge clk);
        frc_done = '0;
        @(negedge clk);
        chk(grant_o == '0, "R5 own done releases", grant_o, 0);
        settle(4);
    endtask

    // R7: an unanswered grant lasts exactly the timeout.
    task automatic t_timeout();
        int len;
        resp_mask = '0;
        status_i = 4'b0100;
        tick();
        status_i = '0;
        len = 0;
        while (grant_o == 4'b0100 && len < 50) begin
            len++;
            @(negedge clk);
        end
        chk(len == TMO, "R7 timeout length", len, TMO);
        chk(grant_o == '0, "R7 released", grant_o, 0);
        settle(4);
    endtask

    // R8: a tick during service is ignored.
    task automatic t_busy_tick();
        int pulses;
        resp_mask = '1;
        status_i = 4'b1001;
        tick();
        status_i = 4'b1111;
        pulses = 0;
        poll_tick = 1'b1;
        @(negedge clk);
        poll_tick = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (cycle_start_o) pulses++;
            @(negedge clk);
        end
        chk(pulses == 0, "R8 no pulse while busy", pulses, 0);
        settle(4);
        chk(grant_o == '0, "R8 no extra cycle", grant_o, 0);
        status_i = '0;
    endtask

    // R9: overrun stays clear under the deadline, sets above it, then sticks.
    task automatic t_overrun();
        resp_mask = '0;
        status_i = 4'b0011;
        tick();
        status_i = '0;
        settle(2 * TMO + 6);
        chk(overrun_o == 1'b0, "R9 short cycle clear", overrun_o, 0);
        status_i = 4'b1111;
        tick();
        status_i = '0;
        settle(4 * TMO + 6);
        chk(overrun_o == 1'b1, "R9 long cycle flagged", overrun_o, 1);
        resp_mask = '1;
        status_i = 4'b0001;
        tick();
        status_i = '0;
        settle(10);
        chk(overrun_o == 1'b1, "R9 flag sticky", overrun_o, 1);
    endtask

    initial begin
        settle(4);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_order();
        t_other_done();
        t_timeout();
        t_busy_tick();
        t_overrun();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule